// File: doc/BRIEF.md
# Flash Access Violation Detector

This block sits beside a small 8-bit microcontroller core and looks at every access that reaches on-chip flash. It classifies three kinds of access. The first is a data-space write or erase, which only reaches flash while the programming write-enable flag is set. The second is a code-space table read. The third is an instruction fetch that results from a branch. It also checks two conditions that do not depend on the address: a restriction computed elsewhere from the security options, and whether the supply-voltage monitor is enabled.

Each address is compared against a configurable lock-byte address. Any address strictly above it lies outside user code space. When an access is illegal, the block raises a registered one-cycle pulse one clock after the access strobe. The reset controller takes this pulse as a system reset request. A 3-bit cause code accompanies the pulse, so reset-source logic can record why the reset happened.

Top module: `flash_guard`

## Requirements
- R1: A data-space write with `prog_wen`=1 and `wr_addr` > `lock_addr` is illegal, with cause code 1.
- R2: A table read with `rd_addr` > `lock_addr` is illegal, with cause code 2.
- R3: A branch fetch with `fetch_addr` > `lock_addr` is illegal, with cause code 3.
- R4: An access whose address equals `lock_addr`, or is below it, is never a range violation on any of the three paths.
- R5: While `sec_block`=1, a flash write (write strobe with `prog_wen`=1) or a table read is illegal, with cause code 4. A branch fetch is not affected by `sec_block`.
- R6: A flash write (write strobe with `prog_wen`=1) while `vmon_en`=0 is illegal, with cause code 5, at any address.
- R7: A write strobe with `prog_wen`=0 never raises an error, whatever its address, `sec_block` or `vmon_en`.
- R8: When several causes hold in the same cycle, the reported code is the lowest of them.
- R9: `err_pulse` is high in exactly the cycle after a cycle that has an illegal access, and low otherwise. `err_cause` is 0 whenever `err_pulse` is 0.
- R10: While `rst_n` is low, `err_pulse` and `err_cause` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lock_addr | input | ADDR_W | Highest address of user code space |
| prog_wen | input | 1 | Programming write-enable flag; data writes go to flash when 1 |
| vmon_en | input | 1 | Supply-voltage monitor enabled |
| sec_block | input | 1 | Security setting forbids the current flash read or write |
| wr_stb | input | 1 | Data-space write or erase strobe |
| wr_addr | input | ADDR_W | Write address |
| rd_stb | input | 1 | Code-space table read strobe |
| rd_addr | input | ADDR_W | Table read address |
| fetch_stb | input | 1 | Branch fetch strobe |
| fetch_addr | input | ADDR_W | Branch target address |
| err_pulse | output | 1 | One-cycle illegal-access pulse (reset request) |
| err_cause | output | 3 | Cause code: 1 write range, 2 read range, 3 fetch range, 4 security, 5 monitor off, 0 none |

## Verification
Several causes can fall in the same cycle. One case is a single flash write above the lock byte while the monitor is off, which is both a range violation and a monitor-off violation. Another is a legal table read under the security restriction that coincides with an out-of-range branch fetch. The bench drives these overlaps on purpose: directed cycles set two or three causes together, and a random phase sets all strobes and flags freely. The bench judges each case by whether the single reported code is the lowest of the true causes, and whether the pulse lands exactly one clock later.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

    localparam int CAUSE_W = 3;
    localparam int N_CAUSE = 5;
    localparam int N_PATH  = 3;

    typedef enum logic [CAUSE_W-1:0] {
        FG_NONE     = 3'd0,
        FG_WR_RANGE = 3'd1,
        FG_RD_RANGE = 3'd2,
        FG_FE_RANGE = 3'd3,
        FG_SECURE   = 3'd4,
        FG_VMON_OFF = 3'd5
    } fg_cause_e;

    typedef struct packed {
        logic      err;
        fg_cause_e cause;
    } fg_state_t;

endpackage

// File: rtl/fg_range_cmp.sv
module fg_range_cmp #(
    parameter int ADDR_W = 16
) (
    input  logic              stb,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] lock,
    output logic              hit
);
    // strictly above the lock byte is outside user space
    always_comb begin
        hit = stb && (addr > lock);
    end
endmodule

// File: rtl/fg_cause_sel.sv
module fg_cause_sel
    import flash_guard_pkg::*;
#(
    parameter int N = N_CAUSE
) (
    input  logic [N-1:0]       flags,
    output logic               any,
    output logic [CAUSE_W-1:0] code
);
    // flag index i reports code i+1; lowest index wins
    always_comb begin
        any  = |flags;
        code = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (flags[i]) begin
                code = CAUSE_W'(i + 1);
            end
        end
    end
endmodule

// File: rtl/flash_guard.sv
module flash_guard
    import flash_guard_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lock_addr,
    input  logic              prog_wen,
    input  logic              vmon_en,
    input  logic              sec_block,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              rd_stb,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              fetch_stb,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              err_pulse,
    output logic [2:0]        err_cause
);
    localparam int PATH_WR = 0;
    localparam int PATH_RD = 1;
    localparam int PATH_FE = 2;

    // a data write only reaches flash with the write-enable flag set
    logic flash_wr;
    assign flash_wr = wr_stb && prog_wen;

    logic [N_PATH-1:0] path_stb;
    logic [ADDR_W-1:0] path_addr [N_PATH];
    logic [N_PATH-1:0] path_hit;

    assign path_stb[PATH_WR]  = flash_wr;
    assign path_stb[PATH_RD]  = rd_stb;
    assign path_stb[PATH_FE]  = fetch_stb;
    assign path_addr[PATH_WR] = wr_addr;
    assign path_addr[PATH_RD] = rd_addr;
    assign path_addr[PATH_FE] = fetch_addr;

    for (genvar g = 0; g < N_PATH; g++) begin : g_path
        fg_range_cmp #(.ADDR_W(ADDR_W)) u_cmp (
            .stb  (path_stb[g]),
            .addr (path_addr[g]),
            .lock (lock_addr),
            .hit  (path_hit[g])
        );
    end

    // flag order sets the priority: index 0 is the lowest code
    logic [N_CAUSE-1:0] flags;
    always_comb begin
        flags[0] = path_hit[PATH_WR];
        flags[1] = path_hit[PATH_RD];
        flags[2] = path_hit[PATH_FE];
        flags[3] = sec_block && (flash_wr || rd_stb);
        flags[4] = flash_wr && !vmon_en;
    end

    logic               sel_any;
    logic [CAUSE_W-1:0] sel_code;

    fg_cause_sel #(.N(N_CAUSE)) u_sel (
        .flags (flags),
        .any   (sel_any),
        .code  (sel_code)
    );

    fg_state_t st_d, st_q;

    always_comb begin
        st_d       = '0;
        st_d.err   = sel_any;
        st_d.cause = sel_any ? fg_cause_e'(sel_code) : FG_NONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign err_pulse = st_q.err;
    assign err_cause = st_q.cause;

endmodule

// File: rtl/flash_guard_chk.sv
module flash_guard_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] lock_addr,
    input logic              prog_wen,
    input logic              vmon_en,
    input logic              sec_block,
    input logic              wr_stb,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              rd_stb,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              fetch_stb,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              err_pulse,
    input logic [2:0]        err_cause
);
    // R9: no pulse without a strobe in the cycle before
    p_pulse_needs_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> $past(wr_stb || rd_stb || fetch_stb));

    // R9: cause is zero when idle, a legal code when pulsing
    p_cause_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !err_pulse |-> (err_cause == 3'd0));

    p_cause_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> (err_cause >= 3'd1 && err_cause <= 3'd5));

    // R7: a write that goes to data memory is harmless on its own
    p_ram_write_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !prog_wen && !rd_stb && !fetch_stb) |=> !err_pulse);

    // R3: a lone fetch above the lock byte reports code 3
    p_fetch_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_stb && fetch_addr > lock_addr && !rd_stb && !wr_stb)
        |=> (err_pulse && err_cause == 3'd3));

    // R4: a lone table read at the lock byte is legal when unrestricted
    p_read_at_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && rd_addr == lock_addr && !sec_block && !wr_stb && !fetch_stb)
        |=> !err_pulse);

    // R1: out-of-range flash write always wins with code 1
    p_write_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && prog_wen && wr_addr > lock_addr)
        |=> (err_pulse && err_cause == 3'd1));
endmodule

bind flash_guard flash_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lock_addr  (lock_addr),
    .prog_wen   (prog_wen),
    .vmon_en    (vmon_en),
    .sec_block  (sec_block),
    .wr_stb     (wr_stb),
    .wr_addr    (wr_addr),
    .rd_stb     (rd_stb),
    .rd_addr    (rd_addr),
    .fetch_stb  (fetch_stb),
    .fetch_addr (fetch_addr),
    .err_pulse  (err_pulse),
    .err_cause  (err_cause)
);

// File: tb/flash_guard_tb.sv
module flash_guard_tb;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] lock_addr = 16'h3BFF;
    logic          prog_wen = 1'b0, vmon_en = 1'b1, sec_block = 1'b0;
    logic          wr_stb = 1'b0, rd_stb = 1'b0, fetch_stb = 1'b0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0, fetch_addr = '0;
    logic          err_pulse;
    logic [2:0]    err_cause;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    flash_guard #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .lock_addr(lock_addr), .prog_wen(prog_wen),
        .vmon_en(vmon_en), .sec_block(sec_block), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .rd_stb(rd_stb), .rd_addr(rd_addr), .fetch_stb(fetch_stb),
        .fetch_addr(fetch_addr), .err_pulse(err_pulse), .err_cause(err_cause)
    );

    // behavioural reference: what code does this cycle's traffic deserve
    function automatic int ref_code();
        int c = 0;
        int cands[$];
        bit fw = wr_stb && prog_wen;
        if (fw && wr_addr > lock_addr)              cands.push_back(1);
        if (rd_stb && rd_addr > lock_addr)          cands.push_back(2);
        if (fetch_stb && fetch_addr > lock_addr)    cands.push_back(3);
        if (sec_block && (fw || rd_stb))            cands.push_back(4);
        if (fw && !vmon_en)                         cands.push_back(5);
        foreach (cands[i]) if (c == 0 || cands[i] < c) c = cands[i];
        return c;
    endfunction

    task automatic compare(input string tag, input int exp_code);
        int exp_p = (exp_code != 0) ? 1 : 0;
        n_cmp++;
        if (int'(err_pulse) != exp_p || int'(err_cause) != exp_code) begin
            n_bad++;
            $display("FAIL %s: pulse=%0d cause=%0d expected pulse=%0d cause=%0d",
                     tag, err_pulse, err_cause, exp_p, exp_code);
        end
    endtask

    // inputs already set (after a negedge); registers at posedge; check after it
    task automatic step(input string tag);
        int e = ref_code();
        @(posedge clk);
        #1;
        compare(tag, e);
        @(negedge clk);
    endtask

    task automatic idle();
        wr_stb = 0; rd_stb = 0; fetch_stb = 0;
        prog_wen = 0; sec_block = 0; vmon_en = 1;
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R10: reset holds outputs low even with illegal traffic present
        wr_stb = 1; prog_wen = 1; wr_addr = 16'hFFFF;
        repeat (3) @(negedge clk);
        compare("R10", 0);
        @(negedge clk);
        compare("R10", 0);
        idle();
        rst_n = 1;
        @(negedge clk);

        // R1
        prog_wen = 1; wr_stb = 1; wr_addr = 16'h3C00; step("R1");
        idle(); step("R9");
        // R4 write exactly at lock
        prog_wen = 1; wr_stb = 1; wr_addr = 16'h3BFF; step("R4");
        idle();
        // R2
        rd_stb = 1; rd_addr = 16'h8000; step("R2");
        rd_addr = 16'h3BFF; step("R4");
        idle();
        // R3
        fetch_stb = 1; fetch_addr = 16'h3C00; step("R3");
        fetch_addr = 16'h3BFF; step("R4");
        fetch_addr = 16'h0100; step("R4");
        idle();
        // R5: security on write and on read, not on fetch
        sec_block = 1; prog_wen = 1; wr_stb = 1; wr_addr = 16'h0010; step("R5");
        idle(); sec_block = 1; rd_stb = 1; rd_addr = 16'h0020; step("R5");
        idle(); sec_block = 1; fetch_stb = 1; fetch_addr = 16'h0030; step("R5");
        idle();
        // R6: monitor off, low address
        vmon_en = 0; prog_wen = 1; wr_stb = 1; wr_addr = 16'h0000; step("R6");
        idle();
        // R7: RAM write with everything hostile
        wr_stb = 1; prog_wen = 0; wr_addr = 16'hFFFF; sec_block = 1; vmon_en = 0;
        step("R7");
        idle();
        // R8: overlaps
        prog_wen = 1; wr_stb = 1; wr_addr = 16'hF000; vmon_en = 0; step("R8");
        idle(); sec_block = 1; rd_stb = 1; rd_addr = 16'h0001;
        fetch_stb = 1; fetch_addr = 16'hFFFF; step("R8");
        idle(); vmon_en = 0; sec_block = 1; prog_wen = 1; wr_stb = 1; wr_addr = 16'h0002;
        step("R8");
        // R9: back-to-back illegal cycles then quiet
        idle(); fetch_stb = 1; fetch_addr = 16'hFFFF; step("R9");
        step("R9");
        idle(); step("R9");
        step("R9");
        // change lock: R4 boundary moves
        lock_addr = 16'h00FF; rd_stb = 1; rd_addr = 16'h0100; step("R2");
        rd_addr = 16'h00FF; step("R4");
        idle();

        // random mix checked against the reference every clock (R8/R9)
        for (int i = 0; i < 3000; i++) begin
            lock_addr = (i % 7 == 0) ? 16'($urandom) : lock_addr;
            prog_wen  = 1'($urandom);
            vmon_en   = 1'($urandom);
            sec_block = ($urandom % 4) == 0;
            wr_stb    = 1'($urandom);
            rd_stb    = 1'($urandom);
            fetch_stb = 1'($urandom);
            wr_addr    = ($urandom % 3 == 0) ? lock_addr : 16'($urandom);
            rd_addr    = ($urandom % 3 == 0) ? lock_addr : 16'($urandom);
            fetch_addr = ($urandom % 3 == 0) ? lock_addr : 16'($urandom);
            step("R8");
        end

        idle(); step("R9");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule